// File: doc/BRIEF.md
# Cartesian Feedback Error Stage with Phase Correction

This block produces the baseband error pair of a digital Cartesian feedback loop around a power amplifier. Each input sample carries three things: the command vector that the transmitter wants, the feedback vector measured after down-conversion, and the angle that separates the two local oscillators. The feedback vector is turned back by that angle with a rotation-mode CORDIC. Its CORDIC gain is removed with a shift-and-add constant multiply. The result is subtracted from the command, and the difference is clipped to the output width.

The command path runs through a delay line that is exactly as long as the rotation pipeline. Each error sample is therefore formed from a command and a feedback taken in the same input cycle. Angles beyond a quarter turn are first folded by a fixed ±90° swap-and-negate step, so the iterations only see residuals within ±90°. The CORDIC iterations are grouped, with several of them per register stage. This keeps the total latency to a few cycles, which leaves room for the angle estimator inside a 12-cycle loop budget.

The block accepts one sample per clock and is fully pipelined. Samples are marked by a valid bit on input and on output.

Top module: `cfb_err_stage`

## Requirements
- R1: The angle input `rot_ang` is a two's-complement fraction of a full turn (value a means a·360/4096 degrees). For |a| < 1024, each output equals the command minus the feedback vector rotated counterclockwise by that angle at unity gain, err_i = cmd_i − (fb_i·cos − fb_q·sin) and err_q = cmd_q − (fb_i·sin + fb_q·cos). Both outputs lie within 40 counts of that value when the feedback magnitude is at most 23000.
- R2: The same accuracy holds for angles at or beyond a quarter turn, including a = 1024, −1024, −1025, 2047 and −2048.
- R3: The error is linear in the feedback. With a feedback of half the rotated-back command, each output is about half the command, with the command's sign and within 40 counts.
- R4: Results outside the signed 16-bit range clip to 32767 or −32768 and never wrap.
- R5: A sample accepted with `in_vld` high at a rising edge appears with `err_vld` high exactly 5 rising edges later. One sample is accepted per cycle, and outputs come out in input order.
- R6: While `err_vld` is low, `err_i` and `err_q` hold their last values. Inputs presented with `in_vld` low have no effect on the outputs.
- R7: While reset is asserted and right after it is released, `err_vld` is 0 and both error outputs are 0.
- R8: A feedback of exactly zero yields errors that equal, bit for bit, the command given in the same input cycle. This holds even when a different command arrives every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample valid |
| cmd_i | input | 16 | Command vector, in-phase, signed |
| cmd_q | input | 16 | Command vector, quadrature, signed |
| fb_i | input | 16 | Feedback vector, in-phase, signed |
| fb_q | input | 16 | Feedback vector, quadrature, signed |
| rot_ang | input | 12 | Correction angle, signed fraction of a full turn |
| err_vld | output | 1 | Error sample valid |
| err_i | output | 16 | Error, in-phase, signed, saturated |
| err_q | output | 16 | Error, quadrature, signed, saturated |

## Verification
Suppose one rotation stage picks the wrong direction bit or a wrong arctangent step. The residual angle would then leave a null test with an error of hundreds of counts, seen on the very sample that carried it and 5 cycles after that sample entered. Suppose instead the command delay line were one stage short or long. Back-to-back samples with zero feedback would then return the neighbouring command, and the first mismatch would appear within one output. Quadrant folding faults only show for angles past ±90°, so those angles and the exact boundaries are exercised on their own.

// File: rtl/cfb_err_pkg.sv
`timescale 1ns/1ps
package cfb_err_pkg;

    // arctangent of 2^-idx as a fraction of a full turn, scaled by 2^20
    function automatic int atan_q20(input int idx);
        case (idx)
            0:  return 131072;
            1:  return 77376;
            2:  return 40883;
            3:  return 20753;
            4:  return 10417;
            5:  return 5213;
            6:  return 2607;
            7:  return 1304;
            8:  return 652;
            9:  return 326;
            10: return 163;
            11: return 81;
            12: return 41;
            13: return 20;
            14: return 10;
            15: return 5;
            default: return 0;
        endcase
    endfunction

    // the same step rounded to an angle column whose full turn is 2^zw (zw <= 19)
    function automatic int atan_step(input int idx, input int zw);
        int v;
        v = atan_q20(idx);
        return (v + (1 <<< (19 - zw))) >>> (20 - zw);
    endfunction

endpackage

// File: rtl/cfb_prerot.sv
`timescale 1ns/1ps
// Quarter-turn fold: brings any angle into +-90 degrees before the iterations.
module cfb_prerot #(
    parameter int DW = 16,
    parameter int IW = 20,
    parameter int AW = 12,
    parameter int ZW = 16,
    parameter int GB = 2
) (
    input  logic signed [DW-1:0] fb_i,
    input  logic signed [DW-1:0] fb_q,
    input  logic signed [AW-1:0] ang,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam logic signed [ZW-1:0] QTR = ZW'(2 ** (ZW - 2));

    logic signed [IW-1:0] xs, ys;
    logic signed [ZW-1:0] zs;

    always_comb begin
        xs = IW'(fb_i);
        ys = IW'(fb_q);
        xs = xs <<< GB;
        ys = ys <<< GB;
        zs = {ang, {(ZW - AW){1'b0}}};
        case (ang[AW-1 -: 2])
            2'b01: begin
                x_o = -ys;
                y_o = xs;
                z_o = zs - QTR;
            end
            2'b10: begin
                x_o = ys;
                y_o = -xs;
                z_o = zs + QTR;
            end
            default: begin
                x_o = xs;
                y_o = ys;
                z_o = zs;
            end
        endcase
    end
endmodule

// File: rtl/cfb_cordic_seg.sv
`timescale 1ns/1ps
// COUNT consecutive rotation-mode iterations, starting at shift FIRST, no register.
module cfb_cordic_seg
    import cfb_err_pkg::*;
#(
    parameter int IW    = 20,
    parameter int ZW    = 16,
    parameter int FIRST = 0,
    parameter int COUNT = 4
) (
    input  logic signed [IW-1:0] x_in,
    input  logic signed [IW-1:0] y_in,
    input  logic signed [ZW-1:0] z_in,
    output logic signed [IW-1:0] x_out,
    output logic signed [IW-1:0] y_out,
    output logic signed [ZW-1:0] z_out
);
    logic signed [IW-1:0] xv, yv, xn;
    logic signed [ZW-1:0] zv, stp;

    always_comb begin
        xv = x_in;
        yv = y_in;
        zv = z_in;
        xn = '0;
        stp = '0;
        for (int k = 0; k < COUNT; k++) begin
            stp = ZW'(atan_step(FIRST + k, ZW));
            if (!zv[ZW-1]) begin
                xn = xv - (yv >>> (FIRST + k));
                yv = yv + (xv >>> (FIRST + k));
                zv = zv - stp;
            end else begin
                xn = xv + (yv >>> (FIRST + k));
                yv = yv - (xv >>> (FIRST + k));
                zv = zv + stp;
            end
            xv = xn;
        end
        x_out = xv;
        y_out = yv;
        z_out = zv;
    end
endmodule

// File: rtl/cfb_gain_sub.sv
`timescale 1ns/1ps
// Removes the CORDIC gain (x 0.60724 by shifts), subtracts from the command,
// rounds off the guard bits and clips to the output width.
module cfb_gain_sub #(
    parameter int DW = 16,
    parameter int IW = 20,
    parameter int GB = 2,
    parameter int OW = 16
) (
    input  logic signed [DW-1:0] cmd,
    input  logic signed [IW-1:0] rot,
    output logic signed [OW-1:0] err
);
    localparam int EW = IW + 2;
    localparam logic signed [EW-1:0] SMAX = EW'(2 ** (OW - 1) - 1);
    localparam logic signed [EW-1:0] SMIN = EW'(-(2 ** (OW - 1)));
    localparam logic signed [EW-1:0] RND  = EW'(2 ** (GB - 1));

    logic signed [EW-1:0] xe, g, ce, e, r;

    always_comb begin
        xe = EW'(rot);
        g  = (xe >>> 1) + (xe >>> 3) - (xe >>> 6) - (xe >>> 9)
           - (xe >>> 12) + (xe >>> 14);
        ce = EW'(cmd);
        ce = ce <<< GB;
        e  = ce - g + RND;
        r  = e >>> GB;
        if (r > SMAX)      err = SMAX[OW-1:0];
        else if (r < SMIN) err = SMIN[OW-1:0];
        else               err = r[OW-1:0];
    end
endmodule

// File: rtl/cfb_err_stage.sv
`timescale 1ns/1ps
module cfb_err_stage #(
    parameter int DW      = 16,
    parameter int OW      = 16,
    parameter int AW      = 12,
    parameter int ZG      = 4,
    parameter int IW      = 20,
    parameter int N_ITER  = 12,
    parameter int PER_REG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] cmd_i,
    input  logic signed [DW-1:0] cmd_q,
    input  logic signed [DW-1:0] fb_i,
    input  logic signed [DW-1:0] fb_q,
    input  logic signed [AW-1:0] rot_ang,
    output logic                 err_vld,
    output logic signed [OW-1:0] err_i,
    output logic signed [OW-1:0] err_q
);
    localparam int ZW   = AW + ZG;
    localparam int GB   = IW - DW - 2;
    localparam int NSEG = (N_ITER + PER_REG - 1) / PER_REG;
    localparam int LAT  = NSEG + 2;

    typedef struct packed {
        logic [NSEG:0]               vld;
        logic [NSEG:0][IW-1:0]       x;
        logic [NSEG:0][IW-1:0]       y;
        logic [NSEG-1:0][ZW-1:0]     z;
        logic [NSEG:0][DW-1:0]       ci;
        logic [NSEG:0][DW-1:0]       cq;
        logic                        ovld;
        logic [OW-1:0]               ei;
        logic [OW-1:0]               eq;
    } pipe_t;

    pipe_t st_d, st_q;

    logic signed [IW-1:0] pre_x, pre_y;
    logic signed [ZW-1:0] pre_z;
    logic signed [IW-1:0] seg_x [NSEG];
    logic signed [IW-1:0] seg_y [NSEG];
    logic signed [ZW-1:0] seg_z [NSEG];
    logic signed [OW-1:0] gi, gq;
    logic                 unused_zres;

    cfb_prerot #(.DW(DW), .IW(IW), .AW(AW), .ZW(ZW), .GB(GB)) u_pre (
        .fb_i(fb_i), .fb_q(fb_q), .ang(rot_ang),
        .x_o(pre_x), .y_o(pre_y), .z_o(pre_z)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int FIRST = s * PER_REG;
        localparam int COUNT = (N_ITER - FIRST < PER_REG) ? (N_ITER - FIRST) : PER_REG;
        cfb_cordic_seg #(.IW(IW), .ZW(ZW), .FIRST(FIRST), .COUNT(COUNT)) u_seg (
            .x_in(st_q.x[s]), .y_in(st_q.y[s]), .z_in(st_q.z[s]),
            .x_out(seg_x[s]), .y_out(seg_y[s]), .z_out(seg_z[s])
        );
    end

    assign unused_zres = ^seg_z[NSEG-1];

    cfb_gain_sub #(.DW(DW), .IW(IW), .GB(GB), .OW(OW)) u_gi (
        .cmd(st_q.ci[NSEG]), .rot(st_q.x[NSEG]), .err(gi)
    );
    cfb_gain_sub #(.DW(DW), .IW(IW), .GB(GB), .OW(OW)) u_gq (
        .cmd(st_q.cq[NSEG]), .rot(st_q.y[NSEG]), .err(gq)
    );

    always_comb begin
        st_d = st_q;
        // stage 0: folded feedback, angle residual and command
        st_d.vld[0] = in_vld;
        if (in_vld) begin
            st_d.x[0]  = pre_x;
            st_d.y[0]  = pre_y;
            st_d.z[0]  = pre_z;
            st_d.ci[0] = cmd_i;
            st_d.cq[0] = cmd_q;
        end
        // iteration groups with the command riding alongside
        for (int s = 0; s < NSEG; s++) begin
            st_d.vld[s+1] = st_q.vld[s];
            if (st_q.vld[s]) begin
                st_d.x[s+1]  = seg_x[s];
                st_d.y[s+1]  = seg_y[s];
                st_d.ci[s+1] = st_q.ci[s];
                st_d.cq[s+1] = st_q.cq[s];
            end
        end
        for (int s = 1; s < NSEG; s++) begin
            if (st_q.vld[s-1]) st_d.z[s] = seg_z[s-1];
        end
        // output register: loads only on a valid sample, holds otherwise
        st_d.ovld = st_q.vld[NSEG];
        if (st_q.vld[NSEG]) begin
            st_d.ei = gi;
            st_d.eq = gq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_vld = st_q.ovld;
    assign err_i   = $signed(st_q.ei);
    assign err_q   = $signed(st_q.eq);

endmodule

// File: rtl/cfb_err_stage_chk.sv
`timescale 1ns/1ps
module cfb_err_stage_chk #(
    parameter int DW  = 16,
    parameter int OW  = 16,
    parameter int LAT = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_vld,
    input logic signed [DW-1:0] cmd_i,
    input logic signed [DW-1:0] cmd_q,
    input logic signed [DW-1:0] fb_i,
    input logic signed [DW-1:0] fb_q,
    input logic                 err_vld,
    input logic signed [OW-1:0] err_i,
    input logic signed [OW-1:0] err_q
);
    logic [LAT-1:0]         vld_sr, fz_sr;
    logic [LAT-1:0][DW-1:0] ci_sr, cq_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_sr <= '0;
            fz_sr  <= '0;
            ci_sr  <= '0;
            cq_sr  <= '0;
        end else begin
            vld_sr <= {vld_sr[LAT-2:0], in_vld};
            fz_sr  <= {fz_sr[LAT-2:0], in_vld && (fb_i == '0) && (fb_q == '0)};
            ci_sr  <= {ci_sr[LAT-2:0], cmd_i};
            cq_sr  <= {cq_sr[LAT-2:0], cmd_q};
        end
    end

    a_r5_latency_match: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld == vld_sr[LAT-1]);

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |-> ($stable(err_i) && $stable(err_q)));

    a_r8_zero_fb_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && fz_sr[LAT-1]) |->
        (err_i == $signed(ci_sr[LAT-1]) && err_q == $signed(cq_sr[LAT-1])));

    a_r7_outputs_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({err_vld, err_i, err_q}));

endmodule

bind cfb_err_stage cfb_err_stage_chk #(.DW(DW), .OW(OW), .LAT(LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .cmd_i(cmd_i), .cmd_q(cmd_q), .fb_i(fb_i), .fb_q(fb_q),
    .err_vld(err_vld), .err_i(err_i), .err_q(err_q)
);

// File: tb/sim_cfb_err_stage.sv
`timescale 1ns/1ps
module sim_cfb_err_stage;
    localparam int    N_ITER  = 12;
    localparam int    PER_REG = 4;
    localparam int    LAT     = 2 + (N_ITER + PER_REG - 1) / PER_REG;
    localparam real   PI      = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [15:0] cmd_i = '0, cmd_q = '0, fb_i = '0, fb_q = '0;
    logic signed [11:0] rot_ang = '0;
    logic err_vld;
    logic signed [15:0] err_i, err_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int    b_ci[32], b_cq[32], b_fi[32], b_fq[32], b_ang[32], b_tol[32];
    string b_tag[32];

    always #2.5 clk = ~clk;

    cfb_err_stage u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .cmd_i(cmd_i), .cmd_q(cmd_q), .fb_i(fb_i), .fb_q(fb_q), .rot_ang(rot_ang),
        .err_vld(err_vld), .err_i(err_i), .err_q(err_q)
    );

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int clip(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic void expect_err(input int ci, input int cq, input int fi, input int fq,
                                       input int ang, output int ei, output int eq);
        real th, ri, rq;
        th = real'(ang) * 2.0 * PI / 4096.0;
        ri = real'(fi) * $cos(th) - real'(fq) * $sin(th);
        rq = real'(fi) * $sin(th) + real'(fq) * $cos(th);
        ei = clip(rnd(real'(ci) - ri));
        eq = clip(rnd(real'(cq) - rq));
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp,
                         input int tol);
        int d;
        n_chk++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int ci, input int cq, input int fi, input int fq,
                         input int ang);
        in_vld  = v;
        cmd_i   = 16'(ci);
        cmd_q   = 16'(cq);
        fb_i    = 16'(fi);
        fb_q    = 16'(fq);
        rot_ang = 12'(ang);
    endtask

    // one entry whose feedback is the command turned back by ang and scaled
    task automatic fill_rot(input int k, input int ang, input real ph, input real amp,
                            input real scl, input string tag, input int tol);
        real th;
        th = real'(ang) * 2.0 * PI / 4096.0;
        b_ci[k]  = rnd(amp * $cos(ph));
        b_cq[k]  = rnd(amp * $sin(ph));
        b_fi[k]  = rnd(scl * (real'(b_ci[k]) * $cos(th) + real'(b_cq[k]) * $sin(th)));
        b_fq[k]  = rnd(scl * (-real'(b_ci[k]) * $sin(th) + real'(b_cq[k]) * $cos(th)));
        b_ang[k] = ang;
        b_tag[k] = tag;
        b_tol[k] = tol;
    endtask

    // drive n samples back to back, check each LAT cycles later
    task automatic run_batch(input int n, input bit sgn);
        for (int c = 0; c < n + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) begin : chk_blk
                int k, ei, eq;
                k = c - LAT;
                expect_err(b_ci[k], b_cq[k], b_fi[k], b_fq[k], b_ang[k], ei, eq);
                check(b_tag[k], "err_vld", int'(err_vld), 1, 0);
                check(b_tag[k], "err_i", int'(err_i), ei, b_tol[k]);
                check(b_tag[k], "err_q", int'(err_q), eq, b_tol[k]);
                if (sgn && (ei > 1000 || ei < -1000))
                    check(b_tag[k], "err_i sign", int'((err_i < 0) == (ei < 0)), 1, 0);
                if (sgn && (eq > 1000 || eq < -1000))
                    check(b_tag[k], "err_q sign", int'((err_q < 0) == (eq < 0)), 1, 0);
            end
            if (c < n) drive(1'b1, b_ci[c], b_cq[c], b_fi[c], b_fq[c], b_ang[c]);
            else       drive(1'b0, 0, 0, 0, 0, 0);
        end
    endtask

    task automatic t_reset;   // R7
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", "err_vld in reset", int'(err_vld), 0, 0);
        check("R7", "err_i in reset", int'(err_i), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "err_vld after reset", int'(err_vld), 0, 0);
        check("R7", "err_q after reset", int'(err_q), 0, 0);
    endtask

    task automatic t_null;    // R1 inside a quarter turn, R2 beyond it
        int angs[13] = '{0, 100, -300, 512, 1000, 1023, 1024, 1500, 2047, -1024, -1025, -1700, -2048};
        for (int k = 0; k < 13; k++)
            fill_rot(k, angs[k], 0.7 * real'(k), 20000.0, 1.0,
                     (angs[k] > -1024 && angs[k] < 1024) ? "R1" : "R2", 40);
        run_batch(13, 1'b0);
    endtask

    task automatic t_scaled;  // R3
        int angs[5] = '{200, 1300, -1800, 600, -500};
        for (int k = 0; k < 5; k++)
            fill_rot(k, angs[k], 0.4 + 1.3 * real'(k), 22000.0, 0.5, "R3", 40);
        run_batch(5, 1'b1);
    endtask

    task automatic t_sat;     // R4
        b_ci[0] = 30000;  b_cq[0] = -30000; b_fi[0] = -30000; b_fq[0] = 30000;  b_ang[0] = 0;
        b_ci[1] = 30000;  b_cq[1] = -30000; b_fi[1] = 30000;  b_fq[1] = -30000; b_ang[1] = -2048;
        b_ci[2] = -32768; b_cq[2] = 32767;  b_fi[2] = 0;      b_fq[2] = -20000; b_ang[2] = 1024;
        for (int k = 0; k < 3; k++) begin
            b_tag[k] = "R4";
            b_tol[k] = 0;
        end
        run_batch(3, 1'b0);
    endtask

    task automatic t_align;   // R8: zero feedback, new command every cycle
        for (int k = 0; k < 10; k++) begin
            b_ci[k]  = (k * 7919) % 65536 - 32768;
            b_cq[k]  = 32767 - k * 3001;
            b_fi[k]  = 0;
            b_fq[k]  = 0;
            b_ang[k] = k * 397 - 2048;
            b_tag[k] = "R8";
            b_tol[k] = 0;
        end
        run_batch(10, 1'b0);
    endtask

    task automatic t_latency; // R5
        @(negedge clk);
        drive(1'b1, 1000, -2000, 0, 0, 0);
        for (int c = 1; c <= LAT + 1; c++) begin
            @(negedge clk);
            if (c == 1) drive(1'b0, 0, 0, 0, 0, 0);
            check("R5", "err_vld timing", int'(err_vld), (c == LAT) ? 1 : 0, 0);
            if (c == LAT) check("R5", "err_i on time", int'(err_i), 1000, 0);
        end
    endtask

    task automatic t_hold;    // R6: follows t_latency, outputs hold 1000 / -2000
        for (int c = 0; c < LAT + 6; c++) begin
            @(negedge clk);
            if (c < 6) drive(1'b0, 12345 - c, -777 * c, 4000 + c, -9000, 300 * c);
            else       drive(1'b0, 0, 0, 0, 0, 0);
            if (c >= 1) begin
                check("R6", "err_vld idle", int'(err_vld), 0, 0);
                check("R6", "err_i held", int'(err_i), 1000, 0);
                check("R6", "err_q held", int'(err_q), -2000, 0);
            end
        end
    endtask

    initial begin
        t_reset();
        t_null();
        t_scaled();
        t_sat();
        t_align();
        t_latency();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule